// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Unit

This block is the control-and-status register file for a single-hart core that runs only at the highest privilege level. It holds five 32-bit registers: interrupt enable, trap vector base, scratch, exception PC and trap cause. It performs the read-modify-write register instructions: write, set-bits and clear-bits. Each of the three has a form that takes a register operand and a form that takes a 5-bit immediate.

The pipeline presents an operation code, a 12-bit register address, the operands and a write enable. It receives the old value of the addressed register combinationally on the read port in the same cycle. When the trap input goes from low to high, the unit records the current PC and the cause code in hardware. This trap capture takes priority over a software write to the same registers in that cycle.

The interrupt-enable, trap-vector and exception-PC registers drive dedicated outputs at all times, so the fetch and interrupt logic can use them directly.

Top module: `mcsr_unit`

## Requirements
- R1: While `rst_n` is low, all five registers clear to zero. Reads of every supported address then return 0, and `mie_o`, `mtvec_o` and `mepc_o` are 0.
- R2: Operation code 3'b001 (write, register operand), applied with `we_i` high, loads `rs_val_i` into the addressed register at the clock edge. The new value is visible from the following cycle.
- R3: Operation code 3'b010 (set, register operand), applied with `we_i` high, loads old OR `rs_val_i`.
- R4: Operation code 3'b011 (clear, register operand), applied with `we_i` high, loads old AND NOT `rs_val_i`.
- R5: Operation codes 3'b101, 3'b110 and 3'b111 are the write, set and clear operations with `imm_i` zero-extended to 32 bits as the operand.
- R6: The address map is: interrupt enable 0x304, trap vector 0x305, scratch 0x340, exception PC 0x341, cause 0x342. A read of any other address returns 0. A write to any other address changes no register.
- R7: `rdata_o` is the addressed register's value before any update in the current cycle. It responds combinationally to `addr_i`.
- R8: In a cycle where `trap_i` is high and was low in the previous cycle, the exception PC loads `pc_i`. The value appears on `mepc_o` one cycle later.
- R9: At that same trap edge, the cause register loads `cause_i`. A read of 0x342 returns that value one cycle later.
- R10: A trap that stays high for more than one cycle captures only once, on its first cycle.
- R11: If a trap edge and a software write to the exception PC or the cause register fall in the same cycle, the trap values win. A software write to any other register in that cycle still takes effect.
- R12: With `we_i` low, or with operation code 3'b000 or 3'b100, no register changes.
- R13: `mie_o`, `mtvec_o` and `mepc_o` always equal the current contents of their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| addr_i | input | 12 | Register address |
| rs_val_i | input | 32 | Register operand |
| imm_i | input | 5 | Immediate operand |
| we_i | input | 1 | Write enable |
| trap_i | input | 1 | Trap request; a rising level triggers capture |
| pc_i | input | 32 | PC of the trapping instruction |
| cause_i | input | 32 | Trap cause code |
| rdata_o | output | 32 | Old value of the addressed register |
| mie_o | output | 32 | Interrupt-enable register |
| mtvec_o | output | 32 | Trap-vector register |
| mepc_o | output | 32 | Exception-PC register |

## Verification
The read port has zero latency. The bench therefore compares `rdata_o` against the model one time unit after it drives the inputs, before the clock edge that commits the operation.

Writes and trap captures land at the next rising edge. The three dedicated outputs are compared at the falling edge that follows, and a captured cause is checked through a read in the next stepped cycle.

A behavioural model is updated once per step, and every output is compared on every cycle. This covers directed cases for each operation, trap persistence, same-cycle collisions, illegal addresses, and a stretch of random traffic.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN  = 32;
  localparam int IMMW  = 5;
  localparam int AW    = 12;
  localparam int NREGS = 5;

  // slot order inside the register array
  localparam int IDX_MIE   = 0;
  localparam int IDX_MTVEC = 1;
  localparam int IDX_SCR   = 2;
  localparam int IDX_MEPC  = 3;
  localparam int IDX_CAUSE = 4;

  localparam logic [AW-1:0] ADDR_MIE   = 12'h304;
  localparam logic [AW-1:0] ADDR_MTVEC = 12'h305;
  localparam logic [AW-1:0] ADDR_SCR   = 12'h340;
  localparam logic [AW-1:0] ADDR_MEPC  = 12'h341;
  localparam logic [AW-1:0] ADDR_CAUSE = 12'h342;

  // bit 2 selects the immediate operand, bits 1:0 the function
  typedef enum logic [2:0] {
    OP_NOP0 = 3'b000, OP_WR  = 3'b001, OP_SET  = 3'b010, OP_CLR  = 3'b011,
    OP_NOP4 = 3'b100, OP_WRI = 3'b101, OP_SETI = 3'b110, OP_CLRI = 3'b111
  } csr_op_e;

  function automatic logic [AW-1:0] slot_addr(input int idx);
    case (idx)
      IDX_MIE:   return ADDR_MIE;
      IDX_MTVEC: return ADDR_MTVEC;
      IDX_SCR:   return ADDR_SCR;
      IDX_MEPC:  return ADDR_MEPC;
      default:   return ADDR_CAUSE;
    endcase
  endfunction
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter int N = NREGS
) (
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o,
  output logic          hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign sel_o[i] = (addr_i == slot_addr(i));
  end
  assign hit_o = |sel_o;
endmodule

// File: rtl/mcsr_alu.sv
module mcsr_alu
  import mcsr_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMMW
) (
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  old_i,
  input  logic [W-1:0]  rs_i,
  input  logic [IW-1:0] imm_i,
  output logic          wr_o,
  output logic [W-1:0]  wdata_o
);
  localparam int PADW = W - IW;
  logic [W-1:0] operand;

  always_comb begin
    operand = op_i[2] ? {{PADW{1'b0}}, imm_i} : rs_i;
    wr_o    = 1'b1;
    case (op_i[1:0])
      2'b01:   wdata_o = operand;
      2'b10:   wdata_o = old_i | operand;
      2'b11:   wdata_o = old_i & ~operand;
      default: begin
        wdata_o = old_i;
        wr_o    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mcsr_regs.sv
module mcsr_regs
  import mcsr_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      sel_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              cap_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      cause_i,
  output logic [N-1:0][W-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic         en;
    logic [W-1:0] d;
    logic [W-1:0] q;

    if (i == IDX_MEPC || i == IDX_CAUSE) begin : g_trap
      always_comb begin
        en = cap_i | (wr_i & sel_i[i]);
        if (cap_i) d = (i == IDX_MEPC) ? pc_i : cause_i;
        else       d = wdata_i;
      end
    end else begin : g_plain
      always_comb begin
        en = wr_i & sel_i[i];
        d  = wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign q_o[i] = q;
  end
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            we_i,
  input  logic            trap_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] cause_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] mepc_o
);
  logic [NREGS-1:0]            sel;
  logic                        hit;
  logic [NREGS-1:0][XLEN-1:0]  regs;
  logic                        alu_wr;
  logic [XLEN-1:0]             wdata;
  logic                        trap_q;
  logic                        trap_rise;
  logic                        sw_wr;

  mcsr_decode #(.N(NREGS)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREGS; i++) rdata_o |= {XLEN{sel[i]}} & regs[i];
  end

  mcsr_alu #(.W(XLEN), .IW(IMMW)) u_alu (
    .op_i    (op_i),
    .old_i   (rdata_o),
    .rs_i    (rs_val_i),
    .imm_i   (imm_i),
    .wr_o    (alu_wr),
    .wdata_o (wdata)
  );

  assign sw_wr = we_i & alu_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_i;
  end
  assign trap_rise = trap_i & ~trap_q;

  mcsr_regs #(.W(XLEN), .N(NREGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel),
    .wr_i    (sw_wr),
    .wdata_i (wdata),
    .cap_i   (trap_rise),
    .pc_i    (pc_i),
    .cause_i (cause_i),
    .q_o     (regs)
  );

  assign mie_o   = regs[IDX_MIE];
  assign mtvec_o = regs[IDX_MTVEC];
  assign mepc_o  = regs[IDX_MEPC];

  AST_TRAP_MEPC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_rise |=> mepc_o == $past(pc_i));                               // R8
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_rise |=> regs[IDX_CAUSE] == $past(cause_i));                   // R9
  AST_MIE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sel[IDX_MIE]) |=> mie_o == $past(wdata));                 // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !trap_rise) |=> $stable(regs));                           // R12
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata_o == '0);                                            // R6
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));                                                     // R6
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !trap_rise) |=> $stable(regs));                            // R6
endmodule

// File: tb/tb_mcsr_unit.sv
`timescale 1ns/1ps
module tb_mcsr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic [11:0] addr;
  logic [31:0] rs_val, pc, cause;
  logic [4:0]  imm;
  logic        we, trap;
  logic [31:0] rdata, mie, mtvec, mepc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] m [5];
  bit          prev_trap;

  always #2.5 clk = ~clk;

  mcsr_unit dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(addr), .rs_val_i(rs_val),
    .imm_i(imm), .we_i(we), .trap_i(trap), .pc_i(pc), .cause_i(cause),
    .rdata_o(rdata), .mie_o(mie), .mtvec_o(mtvec), .mepc_o(mepc)
  );

  function automatic int slot(input logic [11:0] a);
    case (a)
      12'h304: return 0;
      12'h305: return 1;
      12'h340: return 2;
      12'h341: return 3;
      12'h342: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %08h expected %08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: drive at the falling edge, check the read, commit, check outputs
  task automatic step(input string tag, input logic [2:0] o, input logic [11:0] a,
                      input logic [31:0] rv, input logic [4:0] im, input logic w,
                      input logic t, input logic [31:0] p, input logic [31:0] c);
    logic [31:0] nxt [5];
    logic [31:0] opnd, nv;
    int ix;
    op = o; addr = a; rs_val = rv; imm = im; we = w; trap = t; pc = p; cause = c;
    #1;
    ix = slot(a);
    check(tag, "rdata", rdata, (ix >= 0) ? m[ix] : 32'h0);
    for (int k = 0; k < 5; k++) nxt[k] = m[k];
    if (w && ix >= 0 && o[1:0] != 2'b00) begin
      opnd = o[2] ? {27'h0, im} : rv;
      case (o[1:0])
        2'b01:   nv = opnd;
        2'b10:   nv = m[ix] | opnd;
        default: nv = m[ix] & ~opnd;
      endcase
      nxt[ix] = nv;
    end
    if (t && !prev_trap) begin
      nxt[3] = p;
      nxt[4] = c;
    end
    prev_trap = t;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 5; k++) m[k] = nxt[k];
    check(tag, "mie_o",   mie,   m[0]);
    check(tag, "mtvec_o", mtvec, m[1]);
    check(tag, "mepc_o",  mepc,  m[3]);
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    step(tag, 3'b000, a, 32'h0, 5'h0, 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] alist [6];
    alist[0] = 12'h304; alist[1] = 12'h305; alist[2] = 12'h340;
    alist[3] = 12'h341; alist[4] = 12'h342; alist[5] = 12'h7C0;
    for (int k = 0; k < 5; k++) m[k] = 32'h0;
    prev_trap = 0;
    rst_n = 1'b0; op = 3'b000; addr = 12'h304; rs_val = 0; imm = 0;
    we = 0; trap = 0; pc = 0; cause = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int k = 0; k < 5; k++) rd("R1", alist[k]);
    // R2 register-operand write to each slot
    step("R2", 3'b001, 12'h304, 32'hDEAD_BEEF, 0, 1, 0, 0, 0);
    step("R2", 3'b001, 12'h305, 32'h0000_1000, 0, 1, 0, 0, 0);
    step("R2", 3'b001, 12'h340, 32'h1234_5678, 0, 1, 0, 0, 0);
    step("R2", 3'b001, 12'h341, 32'hCAFE_0004, 0, 1, 0, 0, 0);
    step("R2", 3'b001, 12'h342, 32'h8000_000B, 0, 1, 0, 0, 0);
    // R7 read returns pre-update value while a write is pending
    step("R7", 3'b001, 12'h340, 32'hAAAA_5555, 0, 1, 0, 0, 0);
    rd("R7", 12'h340);
    // R3 set / R4 clear
    step("R3", 3'b010, 12'h304, 32'h0F0F_0000, 0, 1, 0, 0, 0);
    step("R4", 3'b011, 12'h304, 32'h0000_BEEF, 0, 1, 0, 0, 0);
    rd("R4", 12'h304);
    // R5 immediate forms, upper operand bits must not leak
    step("R5", 3'b101, 12'h305, 32'hFFFF_FFFF, 5'h1F, 1, 0, 0, 0);
    step("R5", 3'b110, 12'h340, 32'hFFFF_FFFF, 5'h15, 1, 0, 0, 0);
    step("R5", 3'b111, 12'h304, 32'hFFFF_FFFF, 5'h0F, 1, 0, 0, 0);
    rd("R5", 12'h340);
    // R6 illegal address: read zero, write ignored
    step("R6", 3'b001, 12'h343, 32'h5A5A_5A5A, 0, 1, 0, 0, 0);
    step("R6", 3'b101, 12'h300, 32'h0, 5'h1F, 1, 0, 0, 0);
    for (int k = 0; k < 5; k++) rd("R6", alist[k]);
    // R12 we low and no-op codes
    step("R12", 3'b001, 12'h304, 32'h1111_1111, 0, 0, 0, 0, 0);
    step("R12", 3'b000, 12'h305, 32'h2222_2222, 0, 1, 0, 0, 0);
    step("R12", 3'b100, 12'h340, 32'h3333_3333, 5'h1F, 1, 0, 0, 0);
    for (int k = 0; k < 5; k++) rd("R12", alist[k]);
    // R8/R9 trap capture, R10 held trap captures once
    step("R8", 3'b000, 12'h342, 0, 0, 0, 1, 32'h0000_0400, 32'h0000_0002);
    step("R10", 3'b000, 12'h342, 0, 0, 0, 1, 32'h0000_0800, 32'h0000_0007);
    step("R9", 3'b000, 12'h342, 0, 0, 0, 0, 32'h0, 32'h0);
    // R11 trap beats a software write to mepc / mcause, not to mscratch
    step("R11", 3'b001, 12'h341, 32'h9999_9999, 0, 1, 1, 32'h0000_0C00, 32'h0000_000B);
    step("R11", 3'b001, 12'h342, 32'h7777_7777, 0, 1, 0, 0, 0);
    step("R11", 3'b001, 12'h340, 32'h6666_6666, 0, 1, 1, 32'h0000_1004, 32'h8000_0003);
    for (int k = 0; k < 5; k++) rd("R11", alist[k]);
    // R13 random traffic, every output compared every cycle
    for (int n = 0; n < 400; n++) begin
      step("R13", 3'($urandom_range(0, 7)), alist[$urandom_range(0, 5)], $urandom,
           5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 7) == 0), $urandom, $urandom);
    end
    // R1 asynchronous reset clears populated registers
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < 5; k++) m[k] = 32'h0;
    prev_trap = 0;
    check("R1", "mie_o", mie, 32'h0);
    check("R1", "mtvec_o", mtvec, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    trap = 1'b0;
    for (int k = 0; k < 5; k++) rd("R1", alist[k]);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule